// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block paces a small processor core with two pipeline stages. It splits the incoming clock into four phase strobes that take turns, one clock each. Each group of four clocks forms one instruction cycle. The block holds the program counter, which is also the fetch address. It captures the instruction word returned for that address into an instruction register, and that word executes during the next instruction cycle. While one word executes, the next one is being fetched, so straight-line code completes one instruction per cycle.

Execution logic outside the block can ask for a change of flow by raising a branch request together with a target address. The block then loads the target into the program counter and marks the word already fetched as a bubble. A taken branch therefore costs two instruction cycles. The block also emits the data-memory read and write strobes at fixed phases and gates them off for bubble slots. It drives a clock output at one quarter of the input rate, which marks the cycle boundaries. Decoding, the ALU, register contents and the return stack are left to the surrounding core.

Top module: `qseq_top`

## Requirements
- R1: The output `phase` is one-hot, with bit 0 = first phase, bit 1 = second, bit 2 = third and bit 3 = fourth. It advances by one position per clock in that order and wraps from the fourth phase back to the first. The first clock after reset is the first phase.
- R2: `pc` changes only on the clock edge that ends the fourth phase, so it is stable through all four phases of a cycle. Without a taken branch it advances by one, modulo 2^PC_W.
- R3: On the edge that ends the fourth phase, `insn_data` is captured into `insn` and `insn_valid` is set to 1, unless a branch is taken on that edge. Neither output changes on any other edge.
- R4: `rd_stb` is high exactly during the second phase of a cycle in which `insn_valid` is 1. It stays low in every other phase and throughout a bubble cycle.
- R5: `wr_stb` is high exactly during the fourth phase of a cycle in which `insn_valid` is 1. It stays low in every other phase and throughout a bubble cycle.
- R6: If `br_req` is high on the edge that ends the fourth phase of a valid cycle, `pc` takes `br_target` instead of incrementing and `insn_valid` drops to 0. The following cycle fetches the target word and ends with that word in `insn`, `insn_valid` at 1 and `pc` at target+1.
- R7: `br_req` has no effect when it is high only during the first three phases, or during a bubble cycle (`insn_valid` = 0).
- R8: `clk_div` is high during the first and second phases and low during the third and fourth.
- R9: While `rst` is high, `phase` reads 4'b0001, `pc` is 0, `insn_valid` is 0, both strobes are low and `clk_div` is 1. The first cycle after reset is therefore fetch-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_data | input | INSN_W | Instruction word returned for address `pc` |
| br_req | input | 1 | Change-of-flow request from execution |
| br_target | input | PC_W | Branch target address |
| pc | output | PC_W | Program counter and fetch address |
| insn | output | INSN_W | Instruction register (word being executed) |
| insn_valid | output | 1 | Instruction register holds a real word, not a bubble |
| phase | output | 4 | One-hot phase strobes |
| rd_stb | output | 1 | Data-memory operand read strobe |
| wr_stb | output | 1 | Data-memory destination write strobe |
| clk_div | output | 1 | Input clock divided by four |

## Verification
The bench builds the block with PC_W = 4 and INSN_W = 8. It models instruction memory as a word made from the inverted address followed by the address, so every captured word shows which address it came from. The four-bit counter lets a branch to the last address and the bubble after it reach the wrap to zero within a few cycles. Branch requests are given per phase, which reaches a flush, a request during a bubble and a request that drops before the fourth phase.

// File: rtl/qseq_pkg.sv
`timescale 1ns/1ps
package qseq_pkg;
  localparam int NPHASE = 4;
  localparam int PH_A = 0;
  localparam int PH_B = 1;
  localparam int PH_C = 2;
  localparam int PH_D = 3;
  typedef logic [NPHASE-1:0] phase_vec_t;
  localparam phase_vec_t PHASE_RESET = phase_vec_t'(1);
endpackage

// File: rtl/qseq_phase_gen.sv
`timescale 1ns/1ps
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output phase_vec_t phase,
  output logic       clk_div
);
  phase_vec_t phase_nxt;

  always_comb begin
    phase_nxt = {phase[NPHASE-2:0], phase[NPHASE-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PHASE_RESET;
      clk_div <= 1'b1;
    end else begin
      phase   <= phase_nxt;
      clk_div <= phase_nxt[PH_A] | phase_nxt[PH_B];
    end
  end
endmodule

// File: rtl/qseq_pc_unit.sv
`timescale 1ns/1ps
module qseq_pc_unit #(
  parameter int PC_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cyc_end,
  input  logic            take_br,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (cyc_end) begin
      if (take_br) pc <= target;
      else         pc <= pc + PC_ONE;
    end
  end
endmodule

// File: rtl/qseq_fetch_exec.sv
`timescale 1ns/1ps
module qseq_fetch_exec
  import qseq_pkg::*;
#(
  parameter int INSN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_vec_t        phase,
  input  logic              take_br,
  input  logic [INSN_W-1:0] insn_data,
  output logic [INSN_W-1:0] insn,
  output logic              insn_valid,
  output logic              rd_stb,
  output logic              wr_stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      insn       <= '0;
      insn_valid <= 1'b0;
      rd_stb     <= 1'b0;
      wr_stb     <= 1'b0;
    end else begin
      if (phase[PH_D]) begin
        insn       <= insn_data;
        insn_valid <= ~take_br;
      end
      // Strobes are registered one phase ahead of the phase they mark.
      rd_stb <= phase[PH_A] & insn_valid;
      wr_stb <= phase[PH_C] & insn_valid;
    end
  end
endmodule

// File: rtl/qseq_top.sv
`timescale 1ns/1ps
module qseq_top
  import qseq_pkg::*;
#(
  parameter int PC_W   = 9,
  parameter int INSN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn_data,
  input  logic              br_req,
  input  logic [PC_W-1:0]   br_target,
  output logic [PC_W-1:0]   pc,
  output logic [INSN_W-1:0] insn,
  output logic              insn_valid,
  output logic [3:0]        phase,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              clk_div
);
  phase_vec_t ph;
  logic       cyc_end;
  logic       take_br;

  assign cyc_end = ph[PH_D];
  assign take_br = cyc_end & br_req & insn_valid;
  assign phase   = ph;

  qseq_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (ph),
    .clk_div (clk_div)
  );

  qseq_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .cyc_end (cyc_end),
    .take_br (take_br),
    .target  (br_target),
    .pc      (pc)
  );

  qseq_fetch_exec #(.INSN_W(INSN_W)) u_fx (
    .clk        (clk),
    .rst        (rst),
    .phase      (ph),
    .take_br    (take_br),
    .insn_data  (insn_data),
    .insn       (insn),
    .insn_valid (insn_valid),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb)
  );
endmodule

// File: rtl/qseq_chk.sv
`timescale 1ns/1ps
module qseq_chk #(
  parameter int PC_W   = 9,
  parameter int INSN_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              br_req,
  input logic [PC_W-1:0]   br_target,
  input logic [PC_W-1:0]   pc,
  input logic [INSN_W-1:0] insn,
  input logic              insn_valid,
  input logic [3:0]        phase,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              clk_div
);
  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 1);
  // R1
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    phase[0] |=> phase[1]);
  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    phase[3] |=> phase[0]);
  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !phase[3] |=> $stable(pc));
  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !phase[3] |=> ($stable(insn) && $stable(insn_valid)));
  // R4
  rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (phase[1] && insn_valid));
  // R5
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (phase[3] && insn_valid));
  // R6
  branch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && insn_valid && br_req) |=> (pc == $past(br_target) && !insn_valid));
  // R7
  bubble_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (phase[3] && !insn_valid) |=> (pc == $past(pc) + PC_W'(1) && insn_valid));
  // R8
  clk_div_chk: assert property (@(posedge clk) disable iff (rst)
    clk_div == (phase[0] | phase[1]));
endmodule

bind qseq_top qseq_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .br_req     (br_req),
  .br_target  (br_target),
  .pc         (pc),
  .insn       (insn),
  .insn_valid (insn_valid),
  .phase      (phase),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .clk_div    (clk_div)
);

// File: tb/tb_qseq_top.sv
`timescale 1ns/1ps
module tb_qseq_top;
  localparam int PC_W   = 4;
  localparam int INSN_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [INSN_W-1:0] insn_data;
  logic              br_req = 1'b0;
  logic [PC_W-1:0]   br_target = '0;
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] insn;
  logic              insn_valid;
  logic [3:0]        phase;
  logic              rd_stb, wr_stb, clk_div;

  int checks = 0;
  int errors = 0;

  logic [3:0]      s_ph [4];
  logic            s_rd [4];
  logic            s_wr [4];
  logic            s_cd [4];
  logic [PC_W-1:0] s_pc [4];

  always #10 clk = ~clk;

  assign insn_data = {~pc, pc};

  qseq_top #(.PC_W(PC_W), .INSN_W(INSN_W)) dut (
    .clk(clk), .rst(rst), .insn_data(insn_data), .br_req(br_req),
    .br_target(br_target), .pc(pc), .insn(insn), .insn_valid(insn_valid),
    .phase(phase), .rd_stb(rd_stb), .wr_stb(wr_stb), .clk_div(clk_div)
  );

  function automatic logic [INSN_W-1:0] word_at(input logic [PC_W-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One instruction cycle from a first-phase negedge; br_mask bit k drives br_req in phase k.
  task automatic icycle(input logic [3:0] br_mask, input logic [PC_W-1:0] tgt);
    for (int k = 0; k < 4; k++) begin
      br_req    = br_mask[k];
      br_target = tgt;
      s_ph[k] = phase; s_rd[k] = rd_stb; s_wr[k] = wr_stb;
      s_cd[k] = clk_div; s_pc[k] = pc;
      tick();
    end
    br_req = 1'b0;
  endtask

  task automatic check_strobes(input bit valid_cycle, input string tag);
    for (int k = 0; k < 4; k++) begin
      chk(s_rd[k] == (valid_cycle && k == 1), "R4", {tag, " rd_stb"}, s_rd[k], valid_cycle && k == 1);
      chk(s_wr[k] == (valid_cycle && k == 3), "R5", {tag, " wr_stb"}, s_wr[k], valid_cycle && k == 3);
    end
  endtask

  task automatic check_after(input logic [PC_W-1:0] epc, input bit evalid,
                             input logic [PC_W-1:0] eaddr, input string req);
    chk(pc == epc, req, "pc after cycle", pc, epc);
    chk(insn_valid == evalid, req, "insn_valid after cycle", insn_valid, evalid);
    if (evalid) chk(insn == word_at(eaddr), "R3", "captured word", insn, word_at(eaddr));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase == 4'b0001, "R9", "reset phase", phase, 1);
    chk(pc == '0, "R9", "reset pc", pc, 0);
    chk(insn_valid == 1'b0, "R9", "reset valid", insn_valid, 0);
    chk(!rd_stb && !wr_stb, "R9", "reset strobes", {rd_stb, wr_stb}, 0);
    chk(clk_div == 1'b1, "R9", "reset clk_div", clk_div, 1);
    rst = 1'b0;
  endtask

  task automatic t_first_cycles();
    icycle(4'b0000, '0);
    for (int k = 0; k < 4; k++) begin
      chk(s_ph[k] == 4'(1 << k), "R1", "phase order", s_ph[k], 1 << k);
      chk(s_cd[k] == (k < 2), "R8", "clk_div level", s_cd[k], k < 2);
      chk(s_pc[k] == 0, "R2", "pc stable in cycle", s_pc[k], 0);
    end
    check_strobes(1'b0, "fetch-only cycle");
    check_after(4'd1, 1'b1, 4'd0, "R3");
    icycle(4'b0000, '0);
    check_strobes(1'b1, "valid cycle");
    for (int k = 0; k < 4; k++) chk(s_pc[k] == 1, "R2", "pc stable in cycle", s_pc[k], 1);
    check_after(4'd2, 1'b1, 4'd1, "R2");
  endtask

  task automatic t_branch_flush();
    icycle(4'b1000, 4'hB);
    check_strobes(1'b1, "branching cycle");
    check_after(4'hB, 1'b0, 4'h0, "R6");
    icycle(4'b1111, 4'h3);
    check_strobes(1'b0, "bubble cycle");
    check_after(4'hC, 1'b1, 4'hB, "R7");
  endtask

  task automatic t_early_request();
    icycle(4'b0111, 4'h5);
    check_after(4'hD, 1'b1, 4'hC, "R7");
  endtask

  task automatic t_wrap();
    icycle(4'b1000, 4'hF);
    check_after(4'hF, 1'b0, 4'h0, "R6");
    icycle(4'b0000, '0);
    check_after(4'h0, 1'b1, 4'hF, "R2");
    icycle(4'b0000, '0);
    check_strobes(1'b1, "after wrap");
    check_after(4'h1, 1'b1, 4'h0, "R2");
  endtask

  initial begin
    #200us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_cycles();
    t_branch_flush();
    t_early_request();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule